// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block is a small, fully associative cache of page translations. Each entry pairs an address-space identifier and a virtual page number with a physical frame number, a write-permission bit and a pinned flag. A lookup presents an identifier, a page number and an access kind. In the same cycle the block reports one of three results: a hit with the frame, a miss, or a protection fault. Because every entry carries its identifier, a context switch needs no invalidation. Entries from other address spaces simply never match.

After a miss, the surrounding logic walks the page table and installs the result through the fill port. The fill port is a valid/ready stream. A fill is accepted on a cycle where `fill_valid` and `fill_ready` are both high. `fill_ready` is low only while a flush request is present, and the sender must then hold the fill until ready returns. An accepted fill that finds no usable slot is dropped and reported by a one-cycle `fill_err` pulse. Two plain control inputs invalidate either all unpinned entries or the unpinned entries of one identifier.

Top module: `xlat_cache`

## Requirements
- R1: A valid lookup whose identifier and page number both equal those of a stored valid entry raises `lk_hit` in the same cycle and drives that entry's frame on `lk_pfn`.
- R2: An entry whose page number matches but whose identifier differs does not produce a hit.
- R3: A valid lookup with no matching entry raises `lk_miss`, keeps `lk_hit` and `lk_fault` low and drives `lk_pfn` to zero.
- R4: A lookup with `lk_write`=1 (write) that matches an entry stored with `fill_writable`=0 raises `lk_fault` and not `lk_hit`. A read lookup (`lk_write`=0) of that entry is a normal hit.
- R5: A fill that matches no entry goes to the lowest-numbered invalid slot when one exists, so no valid entry is displaced.
- R6: When every slot is valid, a fill evicts the first unpinned entry found by scanning upward, with wraparound, from a rotating pointer. The pointer starts at 0 after reset and moves to one past each victim.
- R7: An entry stored with `fill_wired`=1 is never evicted and survives both kinds of flush.
- R8: When every slot is valid and pinned, an accepted new fill overwrites nothing. `fill_err` is high for exactly the one cycle after acceptance.
- R9: `flush_all` invalidates every unpinned entry at the next clock edge.
- R10: `flush_asid_en` invalidates only the unpinned entries whose identifier equals `flush_asid`, at the next clock edge.
- R11: A fill whose identifier and page number equal those of a valid entry rewrites that entry in place. It creates no duplicate and evicts nothing.
- R12: `fill_ready` is low while either flush input is high, and a fill offered in such a cycle is not installed.
- R13: After reset every entry is invalid, so every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request present |
| lk_asid | input | 8 | Lookup address-space identifier |
| lk_vpn | input | 20 | Lookup virtual page number |
| lk_write | input | 1 | Access kind: 1 write, 0 read |
| lk_hit | output | 1 | Translation found and permitted |
| lk_miss | output | 1 | No matching entry |
| lk_fault | output | 1 | Write to a read-only entry |
| lk_pfn | output | 20 | Frame number on hit or fault, else zero |
| fill_valid | input | 1 | Fill offered |
| fill_ready | output | 1 | Fill can be accepted this cycle |
| fill_asid | input | 8 | Fill identifier |
| fill_vpn | input | 20 | Fill page number |
| fill_pfn | input | 20 | Fill frame number |
| fill_writable | input | 1 | 1 allows writes through this entry |
| fill_wired | input | 1 | 1 pins the entry |
| fill_err | output | 1 | One-cycle pulse: accepted fill had no slot |
| flush_all | input | 1 | Invalidate all unpinned entries |
| flush_asid_en | input | 1 | Invalidate unpinned entries of `flush_asid` |
| flush_asid | input | 8 | Identifier selected for a targeted flush |

## Verification
The bench fills the table completely. It sweeps every slot for both access kinds, so a parity error in the fault decode shows up on half the entries. It then forces evictions with pinned entries sitting directly in front of the rotating pointer. A design that failed to skip pinned slots would lose one of them, and a pointer that did not advance would evict the same slot twice. Three further cases are checked. A refill of an existing key must not cost an extra entry, and a design that duplicated the key would push out a valid translation. A targeted flush must spare pinned entries and entries of other identifiers. A fully pinned table must raise the error pulse and still hold all sixteen translations.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic {ACC_READ = 1'b0, ACC_WRITE = 1'b1} acc_e;
endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
  parameter int N      = 16,
  parameter int ASID_W = 8,
  parameter int VPN_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      ent_valid,
  input  logic [ASID_W-1:0] ent_asid [N],
  input  logic [VPN_W-1:0]  ent_vpn  [N],
  input  logic [ASID_W-1:0] q_asid,
  input  logic [VPN_W-1:0]  q_vpn,
  output logic [N-1:0]      match
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign match[i] = ent_valid[i] && (ent_asid[i] == q_asid) && (ent_vpn[i] == q_vpn);
  end

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match)); // R11
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
  parameter int N = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     ent_valid,
  input  logic [N-1:0]     ent_wired,
  input  logic [IDX_W-1:0] ptr,
  output logic             free_ok,
  output logic [IDX_W-1:0] free_idx,
  output logic             evict_ok,
  output logic [IDX_W-1:0] evict_idx
);
  logic [IDX_W-1:0] cand;

  always_comb begin
    free_ok  = 1'b0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!ent_valid[i]) begin
        free_ok  = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
    evict_ok  = 1'b0;
    evict_idx = '0;
    cand      = '0;
    for (int k = N - 1; k >= 0; k--) begin
      cand = ptr + IDX_W'(k);
      if (ent_valid[cand] && !ent_wired[cand]) begin
        evict_ok  = 1'b1;
        evict_idx = cand;
      end
    end
  end

  AST_VICTIM_UNPINNED: assert property (@(posedge clk) disable iff (!rst_n)
    evict_ok |-> !ent_wired[evict_idx]); // R7
  AST_FREE_IS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    free_ok |-> !ent_valid[free_idx]); // R5
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 8,
  parameter int PFN_W   = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic              lk_write,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic              lk_fault,
  output logic [PFN_W-1:0]  lk_pfn,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [ASID_W-1:0] fill_asid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic              fill_writable,
  input  logic              fill_wired,
  output logic              fill_err,
  input  logic              flush_all,
  input  logic              flush_asid_en,
  input  logic [ASID_W-1:0] flush_asid
);
  import xlat_pkg::*;
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0] ent_valid, ent_wired, ent_wr;
  logic [ASID_W-1:0]  ent_asid [ENTRIES];
  logic [VPN_W-1:0]   ent_vpn  [ENTRIES];
  logic [PFN_W-1:0]   ent_pfn  [ENTRIES];
  logic [IDX_W-1:0]   rr_ptr;

  logic [ENTRIES-1:0] lk_match, fill_match;
  logic               free_ok, evict_ok;
  logic [IDX_W-1:0]   free_idx, evict_idx;

  xlat_match #(.N(ENTRIES), .ASID_W(ASID_W), .VPN_W(VPN_W)) u_lk_cam (
    .clk, .rst_n, .ent_valid, .ent_asid, .ent_vpn,
    .q_asid(lk_asid), .q_vpn(lk_vpn), .match(lk_match));

  xlat_match #(.N(ENTRIES), .ASID_W(ASID_W), .VPN_W(VPN_W)) u_fill_cam (
    .clk, .rst_n, .ent_valid, .ent_asid, .ent_vpn,
    .q_asid(fill_asid), .q_vpn(fill_vpn), .match(fill_match));

  xlat_victim #(.N(ENTRIES)) u_victim (
    .clk, .rst_n, .ent_valid, .ent_wired, .ptr(rr_ptr),
    .free_ok, .free_idx, .evict_ok, .evict_idx);

  // Lookup path: one-hot match selects frame and permission.
  acc_e             lk_kind;
  logic             lk_any, sel_wr;
  logic [PFN_W-1:0] sel_pfn;

  always_comb begin
    lk_kind = acc_e'(lk_write);
    lk_any  = |lk_match;
    sel_wr  = |(lk_match & ent_wr);
    sel_pfn = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lk_match[i]) sel_pfn |= ent_pfn[i];
    end
  end

  assign lk_fault = lk_valid && lk_any && (lk_kind == ACC_WRITE) && !sel_wr;
  assign lk_hit   = lk_valid && lk_any && !lk_fault;
  assign lk_miss  = lk_valid && !lk_any;
  assign lk_pfn   = lk_valid ? sel_pfn : '0;

  // Fill path: in-place update, then free slot, then round-robin victim.
  logic             upd_any, tgt_ok, do_evict, fill_fire, flushing;
  logic [IDX_W-1:0] upd_idx, tgt_idx;

  always_comb begin
    upd_any = |fill_match;
    upd_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (fill_match[i]) upd_idx = IDX_W'(i);
    end
    do_evict = 1'b0;
    tgt_ok   = 1'b1;
    tgt_idx  = '0;
    if (upd_any)       tgt_idx = upd_idx;
    else if (free_ok)  tgt_idx = free_idx;
    else if (evict_ok) begin
      tgt_idx  = evict_idx;
      do_evict = 1'b1;
    end else           tgt_ok = 1'b0;
  end

  assign flushing   = flush_all || flush_asid_en;
  assign fill_ready = !flushing;
  assign fill_fire  = fill_valid && fill_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_valid <= '0;
      ent_wired <= '0;
      ent_wr    <= '0;
      rr_ptr    <= '0;
      fill_err  <= 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
        ent_asid[i] <= '0;
        ent_vpn[i]  <= '0;
        ent_pfn[i]  <= '0;
      end
    end else begin
      fill_err <= 1'b0;
      if (flushing) begin
        for (int i = 0; i < ENTRIES; i++) begin
          if (!ent_wired[i] && (flush_all || ent_asid[i] == flush_asid))
            ent_valid[i] <= 1'b0;
        end
      end else if (fill_fire) begin
        if (tgt_ok) begin
          ent_valid[tgt_idx] <= 1'b1;
          ent_wired[tgt_idx] <= fill_wired;
          ent_wr[tgt_idx]    <= fill_writable;
          ent_asid[tgt_idx]  <= fill_asid;
          ent_vpn[tgt_idx]   <= fill_vpn;
          ent_pfn[tgt_idx]   <= fill_pfn;
          if (do_evict) rr_ptr <= evict_idx + 1'b1;
        end else begin
          fill_err <= 1'b1;
        end
      end
    end
  end

  AST_HIT_NOT_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> !lk_fault); // R4
  AST_MISS_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    lk_miss |-> (!lk_hit && !lk_fault && lk_pfn == '0)); // R3
  AST_ERR_ONLY_PINNED: assert property (@(posedge clk) disable iff (!rst_n)
    fill_err |-> $past(&(ent_valid & ent_wired))); // R8
  AST_ERR_KEEPS_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
    fill_err |-> $stable(ent_valid)); // R8
  AST_PINNED_SURVIVE: assert property (@(posedge clk) disable iff (!rst_n)
    flushing |=> ((ent_valid & $past(ent_valid & ent_wired)) == $past(ent_valid & ent_wired))); // R7
  AST_FLUSH_ALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> ((ent_valid & ~ent_wired) == '0)); // R9
endmodule

// File: tb/sim_xlat_cache.sv
module sim_xlat_cache;
  localparam int PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        lk_valid = 0, lk_write = 0;
  logic [7:0]  lk_asid = 0;
  logic [19:0] lk_vpn = 0;
  logic        lk_hit, lk_miss, lk_fault;
  logic [19:0] lk_pfn;
  logic        fill_valid = 0, fill_writable = 0, fill_wired = 0;
  logic        fill_ready, fill_err;
  logic [7:0]  fill_asid = 0;
  logic [19:0] fill_vpn = 0, fill_pfn = 0;
  logic        flush_all = 0, flush_asid_en = 0;
  logic [7:0]  flush_asid = 0;

  int n_chk = 0, n_bad = 0;

  always #(PERIOD/2) clk = ~clk;

  xlat_cache u0 (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drive a lookup at the falling edge, sample the combinational result 1 ns later.
  task automatic look(input [7:0] a, input [19:0] v, input logic wr);
    @(negedge clk);
    lk_valid = 1; lk_asid = a; lk_vpn = v; lk_write = wr;
    #1;
  endtask

  task automatic expect_hit(string tag, input [7:0] a, input [19:0] v, input [19:0] pfn);
    look(a, v, 1'b0);
    chk(tag, {lk_hit, lk_miss, lk_fault, 9'd0, lk_pfn}, {3'b100, 9'd0, pfn});
  endtask

  task automatic expect_miss(string tag, input [7:0] a, input [19:0] v);
    look(a, v, 1'b0);
    chk(tag, {lk_hit, lk_miss, lk_fault, 9'd0, lk_pfn}, {3'b010, 29'd0});
  endtask

  task automatic fill(input [7:0] a, input [19:0] v, input [19:0] p,
                      input logic w, input logic wd, input logic exp_err);
    @(negedge clk);
    fill_valid = 1; fill_asid = a; fill_vpn = v; fill_pfn = p;
    fill_writable = w; fill_wired = wd;
    @(negedge clk);
    fill_valid = 0;
    chk("R8 fill_err after fill", {31'd0, fill_err}, {31'd0, exp_err});
  endtask

  task automatic flush(input logic all, input logic one, input [7:0] a);
    @(negedge clk);
    flush_all = all; flush_asid_en = one; flush_asid = a;
    @(negedge clk);
    flush_all = 0; flush_asid_en = 0;
  endtask

  initial begin
    #(PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R13: empty after reset
    for (int i = 0; i < 4; i++) expect_miss("R13 reset empty", 8'd1, 20'(i * 5));
    chk("R12 ready idle", {31'd0, fill_ready}, 32'd1);

    // R5: sixteen fills land in free slots; odd slots writable
    for (int i = 0; i < 16; i++) fill(8'd1, 20'(i * 5), 20'(i + 100), i[0], 1'b0, 1'b0);
    for (int i = 0; i < 16; i++) begin
      expect_hit("R1 R5 read hit", 8'd1, 20'(i * 5), 20'(i + 100));
      look(8'd1, 20'(i * 5), 1'b1);
      // R4: write to even (read-only) slot faults
      chk("R4 write access", {30'd0, lk_hit, lk_fault}, i[0] ? 32'd2 : 32'd1);
    end
    // R2, R3
    expect_miss("R2 other asid", 8'd2, 20'd0);
    expect_miss("R3 unknown vpn", 8'd1, 20'd999);

    // R11: refill existing key in place
    fill(8'd1, 20'd5, 20'd500, 1'b1, 1'b0, 1'b0);
    expect_hit("R11 updated pfn", 8'd1, 20'd5, 20'd500);
    for (int i = 0; i < 16; i++)
      if (i != 1) expect_hit("R11 no eviction", 8'd1, 20'(i * 5), 20'(i + 100));

    // R6: round-robin from slot 0
    fill(8'd1, 20'd1000, 20'd7, 1'b1, 1'b0, 1'b0);
    expect_miss("R6 slot0 evicted", 8'd1, 20'd0);
    expect_hit("R6 new entry", 8'd1, 20'd1000, 20'd7);
    fill(8'd1, 20'd1001, 20'd8, 1'b1, 1'b0, 1'b0);
    expect_miss("R6 slot1 evicted", 8'd1, 20'd5);
    expect_hit("R6 slot2 kept", 8'd1, 20'd10, 20'd102);

    // R9: flush all (nothing pinned)
    flush(1'b1, 1'b0, 8'd0);
    for (int i = 2; i < 16; i++) expect_miss("R9 flushed", 8'd1, 20'(i * 5));

    // R7: pin slots 0..3, pointer now 2 -> first victim slot 4
    for (int i = 0; i < 16; i++) fill(8'd3, 20'(200 + i), 20'(300 + i), 1'b1, i < 4, 1'b0);
    fill(8'd3, 20'd300, 20'd1, 1'b1, 1'b0, 1'b0);
    fill(8'd3, 20'd301, 20'd2, 1'b1, 1'b0, 1'b0);
    expect_miss("R7 slot4 victim", 8'd3, 20'd204);
    expect_miss("R6 slot5 victim", 8'd3, 20'd205);
    expect_hit("R6 slot6 kept", 8'd3, 20'd206, 20'd306);
    for (int i = 0; i < 4; i++) expect_hit("R7 pinned kept", 8'd3, 20'(200 + i), 20'(300 + i));

    // R10: targeted flush
    fill(8'd4, 20'd50, 20'd55, 1'b1, 1'b0, 1'b0);
    expect_miss("R6 slot6 victim", 8'd3, 20'd206);
    flush(1'b0, 1'b1, 8'd3);
    expect_hit("R10 other asid kept", 8'd4, 20'd50, 20'd55);
    expect_miss("R10 asid cleared", 8'd3, 20'd300);
    expect_miss("R10 asid cleared", 8'd3, 20'd207);
    for (int i = 0; i < 4; i++) expect_hit("R10 pinned kept", 8'd3, 20'(200 + i), 20'(300 + i));

    // R12: fill offered during flush is refused
    @(negedge clk);
    flush_all = 1; fill_valid = 1; fill_asid = 8'd7; fill_vpn = 20'd77;
    fill_pfn = 20'd9; fill_wired = 0;
    #1 chk("R12 ready low in flush", {31'd0, fill_ready}, 32'd0);
    @(negedge clk);
    flush_all = 0; fill_valid = 0;
    expect_miss("R12 fill dropped", 8'd7, 20'd77);
    expect_miss("R9 other asid cleared", 8'd4, 20'd50);

    // R8: fill the rest pinned, then overflow
    for (int i = 0; i < 12; i++) fill(8'd5, 20'(i), 20'(i + 40), 1'b0, 1'b1, 1'b0);
    fill(8'd5, 20'd99, 20'd3, 1'b1, 1'b0, 1'b1);
    @(negedge clk);
    chk("R8 err single pulse", {31'd0, fill_err}, 32'd0);
    expect_miss("R8 not installed", 8'd5, 20'd99);
    for (int i = 0; i < 12; i++) expect_hit("R8 table intact", 8'd5, 20'(i), 20'(i + 40));
    for (int i = 0; i < 4; i++) expect_hit("R8 table intact", 8'd3, 20'(200 + i), 20'(300 + i));

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule